// File: doc/BRIEF.md
# DMA Channel Enable and Halt Controller

This block controls one DMA channel. Software writes a configuration word that holds an enable bit, a transfer mode, a request-source select, a total unit count and a block length. The block drives a one-cycle go strobe for each data unit it wants moved. The datapath answers each go with a unit-done strobe. Addressing, bus access and the data movement sit outside the block; the unit-done strobe stands in for all of them.

The block decides when units start, how they are grouped, and when the channel stops. The channel can stop for three reasons: the total count runs out, software clears the enable bit, or one of several hardware events occurs. In grouped modes, a software clear waits until the current group has finished. Each hardware event clears the enable bit at once. A readable cause code records why the channel last stopped.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, or in any cycle after `standby` is sampled high, `enBit` reads 0, `stopCause` reads 9 (reset) and `xferGo` stays low.
- R2: With `cfgExtTrig`=0 (auto), the first `xferGo` appears in the cycle after the enabling write. With `cfgExtTrig`=1, no unit starts until `extReq` is sampled in a cycle where `enBit` already reads 1. A request in the cycle of the enabling write is ignored.
- R3: An enabling write with `cfgTotal`=0 leaves `enBit` at 0. While `enBit` reads 1, a write with `cfgEnable`=1 is ignored, and its mode, source, total and block-length fields have no effect.
- R4: In normal mode (`cfgMode` 0, or the unused code 3), a write with `cfgEnable`=0 while enabled makes `enBit` read 0 in the next cycle with `stopCause` 2. No further `xferGo` follows.
- R5: In block mode (`cfgMode` 1) and cluster mode (`cfgMode` 2), a clearing write made inside a group is deferred. `enBit` keeps reading 1 until the unit-done that completes the group, then reads 0 with `stopCause` 2. If no group has started, the clear takes effect at once.
- R6: The group length is 1 in normal mode, `cfgBlkSize` in block mode (0 counts as 1), and the parameter `CLUSTER_UNITS` in cluster mode. In external mode, each accepted request launches one group. A request made while a group is in progress is dropped. In auto mode, groups follow one another without a pause.
- R7: After `cfgTotal` accepted unit-done strobes, `enBit` reads 0 and `stopCause` reads 1. A final group that is shorter than the group length ends early.
- R8: While enabled, each hardware event clears `enBit` in the next cycle and sets its own code: repeat-end 3, area-overflow 4, size-error 5, abort 6, address-error 7, NMI 8.
- R9: When several stop conditions meet in one cycle, the lowest code wins. While `enBit` reads 0, the hardware events are ignored and `stopCause` keeps its value.
- R10: At most one unit is outstanding. After `xferGo`, no further go is issued until a unit-done arrives. `xferGo` never rises while `enBit` reads 0. A unit-done is ignored when no unit is outstanding.
- R11: `stopCause` reads 0 from the cycle after a successful enabling write for as long as `enBit` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; acts as a synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Enable bit value being written |
| cfgMode | input | 2 | 0 normal, 1 block, 2 cluster, 3 treated as normal |
| cfgExtTrig | input | 1 | 1 = units wait for external requests, 0 = auto |
| cfgTotal | input | TOT_W | Total units to move |
| cfgBlkSize | input | BLK_W | Units per block in block mode |
| extReq | input | 1 | External transfer request |
| extAbort | input | 1 | External abort |
| addrErr | input | 1 | Address error |
| nmi | input | 1 | Non-maskable interrupt |
| rptEndIrq | input | 1 | Repeat-size-end halt |
| areaOvfIrq | input | 1 | Extended repeat area overflow halt |
| sizeErrIrq | input | 1 | Transfer size error halt |
| unitDone | input | 1 | Datapath finished one unit |
| xferGo | output | 1 | Start one data unit |
| enBit | output | 1 | Readable enable bit |
| stopCause | output | 4 | Reason for the last stop (0 while running) |

## Verification
The bench targets a clearing write made in the middle of a block or a cluster. A design that applied this write at once would show fewer units than the group length. A design that ignored it would run on to the full total. The bench also drives simultaneous stop conditions, including NMI in the same cycle as the final unit-done. A wrong priority order shows up there as code 8 where code 1 is expected. A request sent during a group must be dropped; a design that queued it would run an extra group. A design that counted the request made in the enabling cycle would start before the channel was armed. Random sessions use varied datapath latency and compare the number of go strobes against the programmed total. They also watch for a second go while a unit is outstanding.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_BLOCK   = 2'd1,
    MODE_CLUSTER = 2'd2,
    MODE_RSVD    = 2'd3
  } xferMode_e;

  typedef enum logic [3:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_DONE    = 4'd1,
    CAUSE_SWSTOP  = 4'd2,
    CAUSE_RPTEND  = 4'd3,
    CAUSE_AREAOVF = 4'd4,
    CAUSE_SIZEERR = 4'd5,
    CAUSE_ABORT   = 4'd6,
    CAUSE_ADDRERR = 4'd7,
    CAUSE_NMI     = 4'd8,
    CAUSE_RESET   = 4'd9
  } stopCause_e;

  // control -> datapath
  typedef struct packed {
    logic loadCfg;
    logic countUnit;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic lastInGroup;
    logic lastInTotal;
    logic midGroup;
    logic grouped;
    logic extTrig;
  } dpStatus_t;

endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int TOT_W         = 16,
  parameter int BLK_W         = 8,
  parameter int CLUSTER_UNITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  ctlStrobes_t      strb,
  input  logic [1:0]       cfgMode,
  input  logic             cfgExtTrig,
  input  logic [TOT_W-1:0] cfgTotal,
  input  logic [BLK_W-1:0] cfgBlkSize,
  output dpStatus_t        stat
);

  localparam int CLU_W = $clog2(CLUSTER_UNITS + 1);
  localparam int POS_W = (BLK_W > CLU_W) ? BLK_W : CLU_W;

  logic [TOT_W-1:0] remCnt;
  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] grpSize;
  logic [POS_W-1:0] cluLen;
  logic [BLK_W-1:0] blkQ;
  xferMode_e        modeQ;
  logic             extQ;
  logic             lastInGroup;
  logic             lastInTotal;

  generate
    if (CLUSTER_UNITS <= 1) begin : g_cluSingle
      assign cluLen = POS_W'(1);
    end else begin : g_cluMulti
      assign cluLen = POS_W'(CLUSTER_UNITS);
    end
  endgenerate

  always_comb begin
    case (modeQ)
      MODE_BLOCK:   grpSize = (blkQ == '0) ? POS_W'(1) : POS_W'(blkQ);
      MODE_CLUSTER: grpSize = cluLen;
      default:      grpSize = POS_W'(1);
    endcase
  end

  assign lastInGroup = (posCnt == grpSize - POS_W'(1));
  assign lastInTotal = (remCnt == TOT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt <= '0;
      posCnt <= '0;
      blkQ   <= '0;
      modeQ  <= MODE_NORMAL;
      extQ   <= 1'b0;
    end else if (standby) begin
      remCnt <= '0;
      posCnt <= '0;
      blkQ   <= '0;
      modeQ  <= MODE_NORMAL;
      extQ   <= 1'b0;
    end else if (strb.loadCfg) begin
      remCnt <= cfgTotal;
      posCnt <= '0;
      blkQ   <= cfgBlkSize;
      modeQ  <= xferMode_e'(cfgMode);
      extQ   <= cfgExtTrig;
    end else if (strb.countUnit) begin
      remCnt <= remCnt - TOT_W'(1);
      posCnt <= (lastInGroup || lastInTotal) ? '0 : posCnt + POS_W'(1);
    end
  end

  assign stat.lastInGroup = lastInGroup;
  assign stat.lastInTotal = lastInTotal;
  assign stat.midGroup    = (posCnt != '0);
  assign stat.grouped     = (modeQ == MODE_BLOCK) || (modeQ == MODE_CLUSTER);
  assign stat.extTrig     = extQ;

  // R6
  pos_in_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    posCnt < grpSize);

  // R7
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countUnit && !standby && !strb.loadCfg) |-> (remCnt != '0));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        standby,
  input  logic        cfgWr,
  input  logic        cfgEnable,
  input  logic        cfgTotalNonZero,
  input  logic        extReq,
  input  logic        extAbort,
  input  logic        addrErr,
  input  logic        nmi,
  input  logic        rptEndIrq,
  input  logic        areaOvfIrq,
  input  logic        sizeErrIrq,
  input  logic        unitDone,
  input  dpStatus_t   stat,
  output ctlStrobes_t strb,
  output logic        xferGo,
  output logic        enBit,
  output logic [3:0]  stopCause
);

  logic       enBitQ;
  logic       busyQ;
  logic       grpActQ;
  logic       pendStopQ;
  stopCause_e causeQ;
  stopCause_e haltCause;

  logic wrSet, wrClr, startOk, countUnit, grpEnd, inGroup;
  logic swNow, pendNow, swLate, halt, anyHw;

  assign wrSet     = cfgWr && cfgEnable;
  assign wrClr     = cfgWr && !cfgEnable;
  assign startOk   = !enBitQ && wrSet && cfgTotalNonZero;
  assign xferGo    = enBitQ && !busyQ && (!stat.extTrig || grpActQ);
  assign countUnit = enBitQ && busyQ && unitDone;
  assign grpEnd    = countUnit && (stat.lastInGroup || stat.lastInTotal);
  assign inGroup   = busyQ || stat.midGroup || xferGo;
  assign swNow     = enBitQ && wrClr && (!stat.grouped || !inGroup);
  assign pendNow   = pendStopQ || (enBitQ && wrClr && stat.grouped && inGroup);
  assign swLate    = grpEnd && pendNow;
  assign anyHw     = rptEndIrq || areaOvfIrq || sizeErrIrq || extAbort || addrErr || nmi;

  // lowest code wins
  always_comb begin
    haltCause = CAUSE_NONE;
    if (enBitQ) begin
      if (countUnit && stat.lastInTotal) haltCause = CAUSE_DONE;
      else if (swNow || swLate)          haltCause = CAUSE_SWSTOP;
      else if (rptEndIrq)                haltCause = CAUSE_RPTEND;
      else if (areaOvfIrq)               haltCause = CAUSE_AREAOVF;
      else if (sizeErrIrq)               haltCause = CAUSE_SIZEERR;
      else if (extAbort)                 haltCause = CAUSE_ABORT;
      else if (addrErr)                  haltCause = CAUSE_ADDRERR;
      else if (nmi)                      haltCause = CAUSE_NMI;
    end
  end

  assign halt = (haltCause != CAUSE_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBitQ    <= 1'b0;
      busyQ     <= 1'b0;
      grpActQ   <= 1'b0;
      pendStopQ <= 1'b0;
      causeQ    <= CAUSE_RESET;
    end else if (standby) begin
      enBitQ    <= 1'b0;
      busyQ     <= 1'b0;
      grpActQ   <= 1'b0;
      pendStopQ <= 1'b0;
      causeQ    <= CAUSE_RESET;
    end else if (halt) begin
      enBitQ    <= 1'b0;
      busyQ     <= 1'b0;
      grpActQ   <= 1'b0;
      pendStopQ <= 1'b0;
      causeQ    <= haltCause;
    end else if (startOk) begin
      enBitQ    <= 1'b1;
      busyQ     <= 1'b0;
      grpActQ   <= 1'b0;
      pendStopQ <= 1'b0;
      causeQ    <= CAUSE_NONE;
    end else if (enBitQ) begin
      if (xferGo)         busyQ <= 1'b1;
      else if (countUnit) busyQ <= 1'b0;
      pendStopQ <= pendNow;
      if (stat.extTrig) begin
        if (grpEnd)                   grpActQ <= 1'b0;
        else if (!grpActQ && extReq)  grpActQ <= 1'b1;
      end
    end
  end

  assign strb.loadCfg   = startOk;
  assign strb.countUnit = countUnit;
  assign enBit          = enBitQ;
  assign stopCause      = causeQ;

  // R2
  ext_armed_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enBitQ) && stat.extTrig) |-> !xferGo);

  // R4
  sw_clear_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBitQ && wrClr && !stat.grouped && !standby) |=> !enBitQ);

  // R5
  sw_clear_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBitQ && wrClr && stat.grouped && busyQ && !unitDone && !anyHw && !standby) |=> enBitQ);

  // R7
  total_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countUnit && stat.lastInTotal && !standby) |=> (!enBitQ && causeQ == CAUSE_DONE));

  // R8
  hw_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBitQ && anyHw && !standby) |=> !enBitQ);

  // R10
  one_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferGo |=> !xferGo);

  // R11
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBitQ == (causeQ == CAUSE_NONE)));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int TOT_W         = 16,
  parameter int BLK_W         = 8,
  parameter int CLUSTER_UNITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic [1:0]       cfgMode,
  input  logic             cfgExtTrig,
  input  logic [TOT_W-1:0] cfgTotal,
  input  logic [BLK_W-1:0] cfgBlkSize,
  input  logic             extReq,
  input  logic             extAbort,
  input  logic             addrErr,
  input  logic             nmi,
  input  logic             rptEndIrq,
  input  logic             areaOvfIrq,
  input  logic             sizeErrIrq,
  input  logic             unitDone,
  output logic             xferGo,
  output logic             enBit,
  output logic [3:0]       stopCause
);

  ctlStrobes_t strb;
  dpStatus_t   stat;

  dma_chan_ctl u_ctl (
    .clk             (clk),
    .rstN            (rstN),
    .standby         (standby),
    .cfgWr           (cfgWr),
    .cfgEnable       (cfgEnable),
    .cfgTotalNonZero (cfgTotal != '0),
    .extReq          (extReq),
    .extAbort        (extAbort),
    .addrErr         (addrErr),
    .nmi             (nmi),
    .rptEndIrq       (rptEndIrq),
    .areaOvfIrq      (areaOvfIrq),
    .sizeErrIrq      (sizeErrIrq),
    .unitDone        (unitDone),
    .stat            (stat),
    .strb            (strb),
    .xferGo          (xferGo),
    .enBit           (enBit),
    .stopCause       (stopCause)
  );

  dma_chan_dp #(
    .TOT_W         (TOT_W),
    .BLK_W         (BLK_W),
    .CLUSTER_UNITS (CLUSTER_UNITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .standby    (standby),
    .strb       (strb),
    .cfgMode    (cfgMode),
    .cfgExtTrig (cfgExtTrig),
    .cfgTotal   (cfgTotal),
    .cfgBlkSize (cfgBlkSize),
    .stat       (stat)
  );

endmodule

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;

  localparam int TOT_W = 16;
  localparam int BLK_W = 8;
  localparam int CLU   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, standby, cfgWr, cfgEnable, cfgExtTrig, extReq, extAbort, addrErr;
  logic nmi, rptEndIrq, areaOvfIrq, sizeErrIrq, unitDone, xferGo, enBit;
  logic [1:0] cfgMode;
  logic [TOT_W-1:0] cfgTotal;
  logic [BLK_W-1:0] cfgBlkSize;
  logic [3:0] stopCause;

  dma_chan_ctrl #(.TOT_W(TOT_W), .BLK_W(BLK_W), .CLUSTER_UNITS(CLU)) u_dma_chan_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgMode(cfgMode), .cfgExtTrig(cfgExtTrig), .cfgTotal(cfgTotal), .cfgBlkSize(cfgBlkSize),
    .extReq(extReq), .extAbort(extAbort), .addrErr(addrErr), .nmi(nmi),
    .rptEndIrq(rptEndIrq), .areaOvfIrq(areaOvfIrq), .sizeErrIrq(sizeErrIrq),
    .unitDone(unitDone), .xferGo(xferGo), .enBit(enBit), .stopCause(stopCause));

  int  checks = 0, errors = 0, goCount = 0, waitCnt = 0, lat = 1, cycles = 0;
  bit  randLat = 0, extRand = 0, nmiWithDone = 0, goWhileOff = 0, overlap = 0;

  function automatic int grpLen(int mode, int blk);
    if (mode == 1) return (blk == 0) ? 1 : blk;
    if (mode == 2) return CLU;
    return 1;
  endfunction

  // index 0..5 = rptEnd, areaOvf, sizeErr, abort, addrErr, nmi
  function automatic int prioCause(bit [5:0] ev);
    for (int i = 0; i < 6; i++) if (ev[i]) return 3 + i;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    cycles++;
    unitDone = 1'b0;
    if (waitCnt > 0) begin
      waitCnt--;
      if (waitCnt == 0) unitDone = 1'b1;
    end
    nmi = nmiWithDone && unitDone;
    if (xferGo) begin
      if (waitCnt > 0 || unitDone) overlap = 1'b1;
      goCount++;
      waitCnt = randLat ? 1 + $urandom_range(0, 2) : lat;
    end
    if (xferGo && !enBit) goWhileOff = 1'b1;
    if (extRand) extReq = ($urandom_range(0, 9) < 3);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic writeCfg(bit en, int mode, bit ext, int total, int blk);
    cfgEnable  = en;
    cfgMode    = 2'(mode);
    cfgExtTrig = ext;
    cfgTotal   = TOT_W'(total);
    cfgBlkSize = BLK_W'(blk);
    cfgWr      = 1'b1;
    cyc();
    cfgWr      = 1'b0;
  endtask

  task automatic hwPulse(bit [5:0] ev);
    {nmi, addrErr, extAbort, sizeErrIrq, areaOvfIrq, rptEndIrq} = ev;
    cyc();
    {nmi, addrErr, extAbort, sizeErrIrq, areaOvfIrq, rptEndIrq} = '0;
  endtask

  task automatic runUntilOff(int maxc);
    for (int i = 0; i < maxc && enBit; i++) cyc();
  endtask

  task automatic fresh();
    idle(6);
    goCount = 0;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g;
    void'($urandom(32'd2024));
    rstN = 0; standby = 0; cfgWr = 0; cfgEnable = 0; cfgMode = 0; cfgExtTrig = 0;
    cfgTotal = 0; cfgBlkSize = 0; extReq = 0; extAbort = 0; addrErr = 0; nmi = 0;
    rptEndIrq = 0; areaOvfIrq = 0; sizeErrIrq = 0; unitDone = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    idle(2);

    // R1 reset state
    chk(enBit == 0, "R1 enBit after reset", enBit, 0);
    chk(stopCause == 9, "R1 cause after reset", stopCause, 9);
    chk(goCount == 0, "R1 no go after reset", goCount, 0);

    // R2/R7/R11 auto normal, 5 units
    fresh(); lat = 1;
    writeCfg(1, 0, 0, 5, 0);
    chk(goCount == 1, "R2 auto go next cycle", goCount, 1);
    chk(stopCause == 0, "R11 cause while running", stopCause, 0);
    runUntilOff(100);
    chk(goCount == 5, "R7 units moved", goCount, 5);
    chk(stopCause == 1, "R7 done cause", stopCause, 1);

    // R2/R3/R6 external normal mode
    fresh();
    extReq = 1;
    writeCfg(1, 0, 1, 3, 0);
    extReq = 0;
    idle(3);
    chk(goCount == 0, "R2 request in write cycle ignored", goCount, 0);
    chk(enBit == 1, "R2 armed", enBit, 1);
    writeCfg(1, 1, 0, 1, 9);
    idle(3);
    chk(goCount == 0 && enBit == 1, "R3 write while enabled ignored", goCount, 0);
    extReq = 1; cyc(); extReq = 0; idle(4);
    chk(goCount == 1, "R6 one unit per request", goCount, 1);
    extReq = 1; cyc(); extReq = 0; idle(4);
    extReq = 1; cyc(); extReq = 0; idle(4);
    chk(goCount == 3, "R3 original total kept", goCount, 3);
    chk(enBit == 0 && stopCause == 1, "R7 ext done", stopCause, 1);

    // R3 zero total
    fresh();
    writeCfg(1, 0, 0, 0, 0);
    idle(2);
    chk(enBit == 0 && goCount == 0, "R3 zero total ignored", enBit, 0);

    // R4 normal clear
    fresh();
    writeCfg(1, 0, 0, 20, 0);
    idle(3);
    writeCfg(0, 0, 0, 0, 0);
    chk(enBit == 0, "R4 clear immediate", enBit, 0);
    chk(stopCause == 2, "R4 sw cause", stopCause, 2);
    g = goCount;
    idle(6);
    chk(goCount == g, "R4 no go after clear", goCount, g);

    // R5 block deferred clear
    fresh(); lat = 2;
    writeCfg(1, 1, 0, 20, 4);
    idle(3);
    writeCfg(0, 1, 0, 0, 0);
    chk(enBit == 1, "R5 block clear deferred", enBit, 1);
    runUntilOff(100);
    chk(goCount == grpLen(1, 4), "R5 block completes", goCount, grpLen(1, 4));
    chk(stopCause == 2, "R5 block sw cause", stopCause, 2);

    // R5 cluster deferred clear
    fresh();
    writeCfg(1, 2, 0, 20, 7);
    idle(3);
    writeCfg(0, 2, 0, 0, 0);
    chk(enBit == 1, "R5 cluster clear deferred", enBit, 1);
    runUntilOff(100);
    chk(goCount == grpLen(2, 7), "R5 cluster completes", goCount, grpLen(2, 7));
    lat = 1;

    // R5 clear before any group
    fresh();
    writeCfg(1, 1, 1, 10, 3);
    idle(2);
    writeCfg(0, 1, 1, 0, 0);
    chk(enBit == 0 && stopCause == 2, "R5 idle group clear immediate", stopCause, 2);

    // R6/R7 external block, extra request dropped, short last block
    fresh();
    writeCfg(1, 1, 1, 7, 3);
    extReq = 1; cyc(); extReq = 0; idle(2);
    extReq = 1; cyc(); extReq = 0; idle(15);
    chk(goCount == 3, "R6 request during group dropped", goCount, 3);
    chk(enBit == 1, "R6 still enabled", enBit, 1);
    extReq = 1; cyc(); extReq = 0; idle(15);
    chk(goCount == 6, "R6 second block", goCount, 6);
    extReq = 1; cyc(); extReq = 0; idle(15);
    chk(goCount == 7 && stopCause == 1, "R7 short last block", goCount, 7);

    // R8 each hardware halt
    for (int k = 0; k < 6; k++) begin
      fresh();
      writeCfg(1, 0, 0, 100, 0);
      idle(2);
      hwPulse(6'(1 << k));
      chk(enBit == 0, "R8 halt clears enable", enBit, 0);
      chk(stopCause == prioCause(6'(1 << k)), "R8 halt code", stopCause, prioCause(6'(1 << k)));
    end

    // R9 priority
    fresh();
    writeCfg(1, 0, 0, 100, 0);
    idle(2);
    hwPulse(6'b111000);
    chk(stopCause == prioCause(6'b111000), "R9 abort beats addr and nmi", stopCause, prioCause(6'b111000));
    fresh();
    writeCfg(1, 1, 0, 100, 2);
    idle(2);
    hwPulse(6'b000101);
    chk(stopCause == prioCause(6'b000101), "R9 rptEnd beats sizeErr", stopCause, prioCause(6'b000101));
    fresh();
    nmiWithDone = 1;
    writeCfg(1, 0, 0, 1, 0);
    idle(3);
    nmiWithDone = 0;
    chk(stopCause == 1, "R9 done beats nmi", stopCause, 1);
    hwPulse(6'b001000);
    chk(stopCause == 1 && enBit == 0, "R9 halt ignored when off", stopCause, 1);

    // R1 standby
    fresh();
    writeCfg(1, 0, 0, 50, 0);
    idle(3);
    standby = 1; cyc(); standby = 0;
    chk(enBit == 0 && stopCause == 9, "R1 standby clears", stopCause, 9);
    g = goCount;
    idle(4);
    chk(goCount == g, "R1 no go after standby", goCount, g);

    // random sessions, R6/R7/R10
    randLat = 1;
    for (int s = 0; s < 30; s++) begin
      int m, e, t, b;
      fresh();
      m = $urandom_range(0, 2);
      e = $urandom_range(0, 1);
      t = $urandom_range(1, 12);
      b = $urandom_range(0, 5);
      extRand = (e == 1);
      writeCfg(1, m, e[0], t, b);
      runUntilOff(600);
      extRand = 0; extReq = 0;
      chk(goCount == t, "R7 random total", goCount, t);
      chk(stopCause == 1 && enBit == 0, "R7 random done cause", stopCause, 1);
    end
    randLat = 0;

    chk(goWhileOff == 0, "R10 go while disabled", goWhileOff, 0);
    chk(overlap == 0, "R10 one outstanding unit", overlap, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule